// File: doc/BRIEF.md
# Memory Controller Handshake Register Stub

This block stands in for the configuration registers of a memory controller, so that boot code can run its usual bring-up sequence against it. That sequence requests initialisation, requests training, then starts impedance calibration and polls a done flag. Here every one of those polls succeeds at once. No memory commands, timing or physical-layer control exist behind the registers.

Three registers are live: a controller configuration word at byte offset 0x000, an impedance (ZQ) control word at 0x0A8 and a ZQ status word at 0x0B0. The bus moves whole 32-bit words, and the register index is the byte offset divided by four. Any other offset in the window reads as zero. Offsets from 0x2E4 to the top of the window are out of range, and an access there raises a one-cycle error pulse.

Top module: `memctl_cfg_stub`

## Requirements
- R1: After reset the configuration word reads 0x80020000, the ZQ control word reads 0x07B00000 and the ZQ status word reads 0x80000000.
- R2: A write to the configuration word stores the written value with bit 31 (init request) and bit 30 (training request) forced to 0, whether either bit, both or neither was written as 1. All other bits are stored unchanged.
- R3: A write to the ZQ control word stores the written value unchanged and sets bit 31 (calibration done) of the ZQ status word. The other status bits keep their previous values.
- R4: A write to the ZQ status word stores the written value unchanged.
- R5: A read of any word offset other than the three live registers returns zero. A write to such an offset leaves all three live registers unchanged.
- R6: Read data is registered. It shows the addressed word one clock after the read enable, and it holds its value in every cycle without a read enable. A read in the same cycle as a write returns the value from before that write.
- R7: An access (read or write) at a byte offset of 0x2E4 or higher drives the error output high for exactly the one cycle after the access. Accesses below 0x2E4, and idle cycles, leave the error output low.
- R8: Address bits 1:0 are ignored. Every access uses the word at the byte address with those bits cleared.
- R9: Reset is synchronous and active-high. It restores all three reset values, clears the read data and clears the error output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | ADDR_W (10) | Byte address in the register window |
| busWrEn | input | 1 | Write enable |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read enable |
| busRdData | output | 32 | Registered read data |
| busErr | output | 1 | One-cycle out-of-range access pulse |

## Verification
A wrong self-clear mask, or a lost ZQ done update, leaves a wrong stored word. That word shows up on the read data at the first read of that register, one clock after its read enable. The bench therefore reads back all three live registers after every single write in a sweep over every word offset. A fault in address decode then appears within a few cycles of the write that exposed it: a write aliasing onto a live register, a dead offset returning data, or an error pulse at the wrong boundary. The range check is exact at both 0x2E0 and 0x2E4.

// File: rtl/memctl_cfg_pkg.sv
`timescale 1ns/1ps
package memctl_cfg_pkg;
  localparam int unsigned DATA_W = 32;

  localparam logic [31:0] CFG_OFS = 32'h0000_0000;
  localparam logic [31:0] ZQC_OFS = 32'h0000_00A8;
  localparam logic [31:0] ZQS_OFS = 32'h0000_00B0;

  localparam logic [DATA_W-1:0] CFG_RST = 32'h8002_0000;
  localparam logic [DATA_W-1:0] ZQC_RST = 32'h07B0_0000;
  localparam logic [DATA_W-1:0] ZQS_RST = 32'h8000_0000;

  // Request bits that complete instantly: init (31) and training (30).
  localparam logic [DATA_W-1:0] CFG_SELFCLR = 32'hC000_0000;
  // Calibration-done flag in the status word.
  localparam logic [DATA_W-1:0] ZQS_DONE = 32'h8000_0000;

  typedef enum logic [1:0] {SEL_ZERO, SEL_CFG, SEL_ZQC, SEL_ZQS} rd_sel_e;

  typedef struct packed {
    logic    wrCfg;
    logic    wrZqc;
    logic    wrZqs;
    logic    rdEn;
    rd_sel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/memctl_cfg_ctrl.sv
`timescale 1ns/1ps
module memctl_cfg_ctrl
  import memctl_cfg_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 10,
  parameter logic [ADDR_W-1:0] OOB_BASE = 10'h2E4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output strobe_t           strobes,
  output logic              busErr
);
  localparam int unsigned WA_W = ADDR_W - 2;
  localparam logic [WA_W-1:0] CFG_W = CFG_OFS[ADDR_W-1:2];
  localparam logic [WA_W-1:0] ZQC_W = ZQC_OFS[ADDR_W-1:2];
  localparam logic [WA_W-1:0] ZQS_W = ZQS_OFS[ADDR_W-1:2];
  localparam logic [WA_W-1:0] OOB_W = OOB_BASE[ADDR_W-1:2];

  logic [WA_W-1:0] wordAddr;
  logic            unusedAddrLow;
  logic            hitCfg, hitZqc, hitZqs, outOfRange;
  logic            errQ;

  assign wordAddr      = busAddr[ADDR_W-1:2];
  assign unusedAddrLow = ^busAddr[1:0];

  assign hitCfg     = (wordAddr == CFG_W);
  assign hitZqc     = (wordAddr == ZQC_W);
  assign hitZqs     = (wordAddr == ZQS_W);
  assign outOfRange = (wordAddr >= OOB_W);

  always_comb begin
    strobes.wrCfg = busWrEn && hitCfg;
    strobes.wrZqc = busWrEn && hitZqc;
    strobes.wrZqs = busWrEn && hitZqs;
    strobes.rdEn  = busRdEn;
    if (hitCfg)      strobes.rdSel = SEL_CFG;
    else if (hitZqc) strobes.rdSel = SEL_ZQC;
    else if (hitZqs) strobes.rdSel = SEL_ZQS;
    else             strobes.rdSel = SEL_ZERO;
  end

  always_ff @(posedge clk) begin
    if (rst) errQ <= 1'b0;
    else     errQ <= (busWrEn || busRdEn) && outOfRange;
  end

  assign busErr = errQ;
endmodule

// File: rtl/memctl_cfg_dp.sv
`timescale 1ns/1ps
module memctl_cfg_dp
  import memctl_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] cfgReg, zqcReg, zqsReg, rdQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgReg <= CFG_RST;
      zqcReg <= ZQC_RST;
      zqsReg <= ZQS_RST;
    end else begin
      if (strobes.wrCfg) cfgReg <= wrData & ~CFG_SELFCLR;
      if (strobes.wrZqc) zqcReg <= wrData;
      if (strobes.wrZqs)      zqsReg <= wrData;
      else if (strobes.wrZqc) zqsReg <= zqsReg | ZQS_DONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdQ <= '0;
    else if (strobes.rdEn) begin
      unique case (strobes.rdSel)
        SEL_CFG: rdQ <= cfgReg;
        SEL_ZQC: rdQ <= zqcReg;
        SEL_ZQS: rdQ <= zqsReg;
        default: rdQ <= '0;
      endcase
    end
  end

  assign rdData = rdQ;
endmodule

// File: rtl/memctl_cfg_stub.sv
`timescale 1ns/1ps
module memctl_cfg_stub
  import memctl_cfg_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 10,
  parameter logic [ADDR_W-1:0] OOB_BASE = 10'h2E4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  output logic              busErr
);
  strobe_t strobes;

  memctl_cfg_ctrl #(.ADDR_W(ADDR_W), .OOB_BASE(OOB_BASE)) u_ctrl (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .strobes(strobes), .busErr(busErr)
  );

  memctl_cfg_dp u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .wrData(busWrData), .rdData(busRdData)
  );
endmodule

// File: rtl/memctl_cfg_stub_chk.sv
`timescale 1ns/1ps
module memctl_cfg_stub_chk
  import memctl_cfg_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 10,
  parameter logic [ADDR_W-1:0] OOB_BASE = 10'h2E4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [DATA_W-1:0] busRdData,
  input logic              busErr
);
  localparam int unsigned WA_W = ADDR_W - 2;
  localparam logic [WA_W-1:0] CFG_W = CFG_OFS[ADDR_W-1:2];
  localparam logic [WA_W-1:0] ZQC_W = ZQC_OFS[ADDR_W-1:2];
  localparam logic [WA_W-1:0] ZQS_W = ZQS_OFS[ADDR_W-1:2];
  localparam logic [WA_W-1:0] OOB_W = OOB_BASE[ADDR_W-1:2];

  logic [WA_W-1:0] wa;
  logic            unusedLow;
  logic            live, anyAcc;
  assign wa        = busAddr[ADDR_W-1:2];
  assign unusedLow = ^busAddr[1:0];
  assign live      = (wa == CFG_W) || (wa == ZQC_W) || (wa == ZQS_W);
  assign anyAcc    = busWrEn || busRdEn;

  AST_CFG_SELFCLR: assert property (@(posedge clk) disable iff (rst)
    (busWrEn && wa == CFG_W) ##1 (busRdEn && !busWrEn && wa == CFG_W)
    |=> busRdData[31:30] == 2'b00); // R2

  AST_ZQ_DONE: assert property (@(posedge clk) disable iff (rst)
    (busWrEn && wa == ZQC_W) ##1 (busRdEn && !busWrEn && wa == ZQS_W)
    |=> busRdData[31]); // R3

  AST_DEAD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (busRdEn && !live) |=> busRdData == '0); // R5

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !busRdEn |=> $stable(busRdData)); // R6

  AST_OOB_ERR: assert property (@(posedge clk) disable iff (rst)
    (anyAcc && wa >= OOB_W) |=> busErr); // R7

  AST_NO_SPURIOUS_ERR: assert property (@(posedge clk) disable iff (rst)
    !(anyAcc && wa >= OOB_W) |=> !busErr); // R7
endmodule

bind memctl_cfg_stub memctl_cfg_stub_chk #(.ADDR_W(ADDR_W), .OOB_BASE(OOB_BASE)) u_chk (
  .clk(clk), .rst(rst), .busAddr(busAddr), .busWrEn(busWrEn),
  .busRdEn(busRdEn), .busRdData(busRdData), .busErr(busErr)
);

// File: tb/sim_memctl_cfg_stub.sv
`timescale 1ns/1ps
module sim_memctl_cfg_stub;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        busErr;

  int errors = 0;
  int checks = 0;
  logic [31:0] mCfg, mZqc, mZqs;

  always #2.5 clk = ~clk;

  memctl_cfg_stub u0 (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData), .busErr(busErr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wrAcc(logic [9:0] a, logic [31:0] d, output logic e);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    e = busErr;
  endtask

  task automatic rdAcc(logic [9:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData; e = busErr;
  endtask

  task automatic chkLive(string tag);
    logic [31:0] d; logic e;
    rdAcc(10'h000, d, e); chk({tag, " cfg"}, d, mCfg);
    rdAcc(10'h0A8, d, e); chk({tag, " zqc"}, d, mZqc);
    rdAcc(10'h0B0, d, e); chk({tag, " zqs"}, d, mZqs);
  endtask

  function automatic logic [31:0] pat(int i);
    logic [7:0] b;
    b = i[7:0];
    return {b, ~b, b ^ 8'h5A, b + 8'd1};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%08h expected=%08h", 32'd0, 32'd1);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d; logic e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R9 rdata after reset", busRdData, 32'h0);
    chk("R9 err after reset", {31'b0, busErr}, 32'h0);
    mCfg = 32'h8002_0000; mZqc = 32'h07B0_0000; mZqs = 32'h8000_0000;
    chkLive("R1 reset");

    // R2: all four combinations of the request bits
    for (int k = 0; k < 4; k++) begin
      d = {k[1:0], 30'h1234_5678 ^ (k * 30'h0101_0101)};
      wrAcc(10'h000, d, e);
      mCfg = d & 32'h3FFF_FFFF;
      chkLive("R2 selfclr");
    end
    wrAcc(10'h000, 32'hFFFF_FFFF, e); mCfg = 32'h3FFF_FFFF; chkLive("R2 all ones");

    // R3/R4: status word kept apart from control word
    wrAcc(10'h0B0, 32'h0000_1234, e); mZqs = 32'h0000_1234; chkLive("R4 zqs write");
    wrAcc(10'h0A8, 32'h0000_0000, e); mZqc = 0; mZqs = 32'h8000_1234; chkLive("R3 zq done");
    wrAcc(10'h0B0, 32'h0000_0000, e); mZqs = 0; chkLive("R4 zqs clear");

    // R8: low address bits ignored
    wrAcc(10'h0AB, 32'hCAFE_0001, e); mZqc = 32'hCAFE_0001; mZqs = 32'h8000_0000;
    chkLive("R8 low bits write");
    rdAcc(10'h0AA, d, e); chk("R8 low bits read", d, 32'hCAFE_0001);
    rdAcc(10'h2E7, d, e); chk("R8 oob low bits err", {31'b0, e}, 32'h1);

    // Sweep every word offset: write, read back, check live set and error
    for (int i = 0; i < 256; i++) begin
      logic [9:0] a;
      logic expErr;
      a = 10'(i * 4);
      expErr = (i * 4) >= 32'h2E4;
      wrAcc(a, pat(i), e);
      chk("R7 write err", {31'b0, e}, {31'b0, expErr});
      if (i == 0) mCfg = pat(i) & 32'h3FFF_FFFF;
      else if (i == 42) begin mZqc = pat(i); mZqs = mZqs | 32'h8000_0000; end
      else if (i == 44) mZqs = pat(i);
      rdAcc(a, d, e);
      chk("R7 read err", {31'b0, e}, {31'b0, expErr});
      if (i == 0) chk("R2 sweep", d, mCfg);
      else if (i == 42) chk("R3 sweep", d, mZqc);
      else if (i == 44) chk("R4 sweep", d, mZqs);
      else chk("R5 dead read", d, 32'h0);
      chkLive("R5 dead write");
    end

    // R6: hold and read-before-write in the same cycle
    rdAcc(10'h0A8, d, e);
    repeat (3) @(negedge clk);
    chk("R6 hold", busRdData, mZqc);
    @(negedge clk);
    busAddr = 10'h0A8; busWrData = 32'h1111_2222; busWrEn = 1'b1; busRdEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busRdEn = 1'b0;
    chk("R6 read old", busRdData, mZqc);
    mZqc = 32'h1111_2222; mZqs = mZqs | 32'h8000_0000;
    chkLive("R6 write landed");
    @(negedge clk);
    chk("R7 idle no err", {31'b0, busErr}, 32'h0);

    // R9: mid-run reset restores values
    wrAcc(10'h2E4, 32'h0, e);
    chk("R7 err pulse", {31'b0, e}, 32'h1);
    @(negedge clk);
    chk("R7 err one cycle", {31'b0, busErr}, 32'h0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9 rdata cleared", busRdData, 32'h0);
    mCfg = 32'h8002_0000; mZqc = 32'h07B0_0000; mZqs = 32'h8000_0000;
    chkLive("R9 reset values");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule